// File: doc/BRIEF.md
# USB Device Control and Status Register Front End

This block is the register window that software uses to steer a small full-speed USB device function. A CPU reaches it over a plain 8-bit bus: a 2-bit address, a write strobe, write data and read data that is registered (one cycle of latency). Three locations are decoded. The control location lets software switch off the transceiver regulator, force the interface into suspend, and hold the interface in reset. The device address location holds the 7-bit address that the host assigns during enumeration. The status location is read-only and shows the last completed transfer.

The serial interface engine feeds the block with single-cycle strobes: bus reset seen, bus activity seen, and transfer completed, with the upper PID bits, endpoint number and direction. Hardware can clear control and address state on its own. Bus activity releases suspend. A bus reset, or a forced reset, wipes the device address. Leaving a forced reset, or seeing a bus reset, raises a one-cycle interrupt request when that interrupt is enabled. A ready flag reports when the regulator has been on long enough to settle.

Top module: `usbd_csr_top`

## Requirements
- R1: After synchronous reset every readable location returns 00h and the outputs regu_off, susp, if_rst and irq_rst are low.
- R2: Control bit 2 (address 0) drives regu_off. Writing 1 turns the regulator off and writing 0 turns it on.
- R3: Control bit 1 drives susp. Software can set or clear it, and a bus activity strobe clears it in the next cycle.
- R4: Control bit 0 drives if_rst for as long as it is 1. A software write that changes it from 1 to 0 pulses irq_rst for exactly one cycle when irq_rst_en is high, and does not pulse it when irq_rst_en is low.
- R5: A bus reset strobe pulses irq_rst for one cycle when irq_rst_en is high.
- R6: The device address (address 1) stores write bits 6:0. Bit 7 always reads 0.
- R7: The device address clears on a bus reset strobe, and it stays 0 (writes are lost) while control bit 0 is 1.
- R8: A completed transfer on endpoint 0 stores the upper two PID bits in status bits 7:6 (address 2). With the lower bits implied as 01: 00 is OUT, 10 is IN, 11 is SETUP.
- R9: A completed transfer on endpoint 1 or 2 sets status bit 5 to 1 for IN and to 0 for OUT. Endpoint 0 transfers leave bit 5 unchanged.
- R10: Status bits 4:3 hold the endpoint of the last transfer (00, 01, 10). Endpoint code 11 is ignored. Bits 2:0 read 0. Writes to address 2 change nothing.
- R11: Control bit 3 (read-only) goes to 1 only once regu_off has been low for SETTLE_CYC clock edges. It reads 0 as soon as bit 2 is 1.
- R12: Read data shows the location addressed in the previous cycle. Address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sie_bus_reset | input | 1 | Bus reset seen strobe |
| sie_activity | input | 1 | Bus activity seen strobe |
| sie_xfer_ok | input | 1 | Transfer completed strobe |
| sie_pid_hi | input | 2 | Upper two bits of the token PID |
| sie_ep | input | 2 | Endpoint number of the transfer |
| sie_dir_in | input | 1 | 1 for IN, 0 for OUT |
| irq_rst_en | input | 1 | Reset interrupt enable |
| regu_off | output | 1 | Regulator disable |
| susp | output | 1 | Suspend request |
| if_rst | output | 1 | Interface held in reset |
| irq_rst | output | 1 | One-cycle reset interrupt request |

## Verification
The hardest case to reach is the exact edge at which the ready flag rises. That edge depends on a long count that restarts every time the regulator is switched off. The stimulus turns the regulator off and then on, waits a computed number of cycles, and issues two reads back to back. The first read must still show the flag clear and the second must show it set. Status retention is also awkward to reach: the bench orders transfers so that an endpoint 0 transfer follows an IN transfer on endpoint 1, which shows that bit 5 keeps its old value.

// File: rtl/usbd_csr_pkg.sv
package usbd_csr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] LOC_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] LOC_DEVA = 2'd1;
  localparam logic [ADDR_W-1:0] LOC_STAT = 2'd2;
  localparam int unsigned DEVA_W = 7;
endpackage

// File: rtl/usbd_ctrl_reg.sv
module usbd_ctrl_reg #(
  parameter int unsigned SETTLE_CYC = 375
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wdata,
  input  logic       bus_reset,
  input  logic       activity,
  input  logic       irq_en,
  output logic       pdwn_q,
  output logic       fsusp_q,
  output logic       fres_q,
  output logic       ready,
  output logic       irq_q
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;
  logic          release_wr;

  assign release_wr = wr_en && fres_q && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pdwn_q  <= 1'b0;
      fsusp_q <= 1'b0;
      fres_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        pdwn_q <= wdata[2];
        fres_q <= wdata[0];
      end
      if (activity)   fsusp_q <= 1'b0;
      else if (wr_en) fsusp_q <= wdata[1];
      irq_q <= irq_en && (release_wr || bus_reset);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pdwn_q)     cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = !pdwn_q && (cnt_q == LIMIT);

  a_r3_activity_clears_susp: assert property (@(posedge clk) disable iff (rst)
    activity |=> !fsusp_q);
  a_r4_irq_on_release: assert property (@(posedge clk) disable iff (rst)
    ($fell(fres_q) && $past(irq_en)) |-> irq_q);
  a_r4_no_irq_when_masked: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_q);
endmodule

// File: rtl/usbd_addr_reg.sv
module usbd_addr_reg #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wdata,
  input  logic          clr,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)  addr_q <= '0;
    else if (wr_en)  addr_q <= wdata;
  end

  a_r7_addr_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (addr_q == '0));
endmodule

// File: rtl/usbd_stat_reg.sv
module usbd_stat_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       xfer_ok,
  input  logic [1:0] pid_hi,
  input  logic [1:0] ep,
  input  logic       dir_in,
  output logic [7:0] stat
);
  logic [1:0] pid_q;
  logic       dir_q;
  logic [1:0] ep_q;
  logic       ep_valid;

  assign ep_valid = (ep != 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      pid_q <= '0;
      dir_q <= 1'b0;
      ep_q  <= '0;
    end else if (xfer_ok && ep_valid) begin
      ep_q <= ep;
      if (ep == 2'b00) pid_q <= pid_hi;
      else             dir_q <= dir_in;
    end
  end

  assign stat = {pid_q, dir_q, ep_q, 3'b000};

  a_r8_pid_captured: assert property (@(posedge clk) disable iff (rst)
    (xfer_ok && ep == 2'b00) |=> (stat[7:6] == $past(pid_hi)));
  a_r9_dir_kept_ep0: assert property (@(posedge clk) disable iff (rst)
    (xfer_ok && ep == 2'b00) |=> $stable(stat[5]));
endmodule

// File: rtl/usbd_csr_top.sv
module usbd_csr_top
  import usbd_csr_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 375
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sie_bus_reset,
  input  logic              sie_activity,
  input  logic              sie_xfer_ok,
  input  logic [1:0]        sie_pid_hi,
  input  logic [1:0]        sie_ep,
  input  logic              sie_dir_in,
  input  logic              irq_rst_en,
  output logic              regu_off,
  output logic              susp,
  output logic              if_rst,
  output logic              irq_rst
);
  logic              wr_ctrl, wr_deva;
  logic              pdwn, fsusp, fres, ready;
  logic [DEVA_W-1:0] deva;
  logic [7:0]        stat;
  logic              unused_wbit;

  assign wr_ctrl     = bus_wr && (bus_addr == LOC_CTRL);
  assign wr_deva     = bus_wr && (bus_addr == LOC_DEVA);
  assign unused_wbit = bus_wdata[7];

  usbd_ctrl_reg #(.SETTLE_CYC(SETTLE_CYC)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(wr_ctrl), .wdata(bus_wdata[2:0]),
    .bus_reset(sie_bus_reset), .activity(sie_activity), .irq_en(irq_rst_en),
    .pdwn_q(pdwn), .fsusp_q(fsusp), .fres_q(fres), .ready(ready), .irq_q(irq_rst)
  );

  usbd_addr_reg #(.AW(DEVA_W)) deva_i (
    .clk(clk), .rst(rst), .wr_en(wr_deva), .wdata(bus_wdata[DEVA_W-1:0]),
    .clr(sie_bus_reset || fres), .addr_q(deva)
  );

  usbd_stat_reg stat_i (
    .clk(clk), .rst(rst), .xfer_ok(sie_xfer_ok), .pid_hi(sie_pid_hi),
    .ep(sie_ep), .dir_in(sie_dir_in), .stat(stat)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        LOC_CTRL: bus_rdata <= {4'b0000, ready, pdwn, fsusp, fres};
        LOC_DEVA: bus_rdata <= {1'b0, deva};
        LOC_STAT: bus_rdata <= stat;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign regu_off = pdwn;
  assign susp     = fsusp;
  assign if_rst   = fres;

  a_r5_bus_reset_irq: assert property (@(posedge clk) disable iff (rst)
    (sie_bus_reset && irq_rst_en) |=> irq_rst);
  a_r6_deva_msb_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr == LOC_DEVA) |-> !bus_rdata[7]);
endmodule

// File: tb/usbd_csr_top_tb_top.sv
module usbd_csr_top_tb_top;
  localparam int SETTLE = 375;

  typedef struct {
    logic [1:0] a;
    logic [7:0] exp;
    string      tag;
  } rd_item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sie_bus_reset = 1'b0, sie_activity = 1'b0, sie_xfer_ok = 1'b0;
  logic [1:0] sie_pid_hi = '0, sie_ep = '0;
  logic       sie_dir_in = 1'b0, irq_rst_en = 1'b0;
  logic       regu_off, susp, if_rst, irq_rst;

  int total = 0;
  int bad = 0;
  rd_item_t sb_q[$];

  always #4 clk = ~clk;

  usbd_csr_top #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sie_bus_reset(sie_bus_reset), .sie_activity(sie_activity),
    .sie_xfer_ok(sie_xfer_ok), .sie_pid_hi(sie_pid_hi), .sie_ep(sie_ep),
    .sie_dir_in(sie_dir_in), .irq_rst_en(irq_rst_en),
    .regu_off(regu_off), .susp(susp), .if_rst(if_rst), .irq_rst(irq_rst)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: compares queued read expectations one negedge after capture
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        rd_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    it.a = a; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic xfer(input logic [1:0] pid, input logic [1:0] ep, input logic din);
    @(negedge clk);
    sie_xfer_ok = 1'b1; sie_pid_hi = pid; sie_ep = ep; sie_dir_in = din;
    @(negedge clk);
    sie_xfer_ok = 1'b0;
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 outs", {4'b0, regu_off, susp, if_rst, irq_rst}, 8'h00);
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 addr");
    rd(2'd2, 8'h00, "R1 stat");
    // R2 / R11 regulator and ready
    wr(2'd0, 8'h04);
    chk("R2 regu_off set", {7'b0, regu_off}, 8'h01);
    rd(2'd0, 8'h04, "R11 ready clear while off");
    wr(2'd0, 8'h00);
    chk("R2 regu_off clr", {7'b0, regu_off}, 8'h00);
    repeat (SETTLE - 2) @(negedge clk);
    rd(2'd0, 8'h00, "R11 ready one cycle early");
    rd(2'd0, 8'h08, "R11 ready at limit");
    // R6 address
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h7F, "R6 msb reads zero");
    wr(2'd1, 8'h2A);
    rd(2'd1, 8'h2A, "R6 address stored");
    // R4 / R7 forced reset
    wr(2'd0, 8'h01);
    chk("R4 if_rst held", {7'b0, if_rst}, 8'h01);
    rd(2'd0, 8'h09, "R4 ctrl fres");
    wr(2'd1, 8'h55);
    rd(2'd1, 8'h00, "R7 cleared while forced");
    irq_rst_en = 1'b1;
    wr(2'd0, 8'h00);
    chk("R4 irq pulse", {7'b0, irq_rst}, 8'h01);
    @(negedge clk);
    chk("R4 irq one cycle", {7'b0, irq_rst}, 8'h00);
    chk("R4 if_rst released", {7'b0, if_rst}, 8'h00);
    irq_rst_en = 1'b0;
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h00);
    chk("R4 masked no irq", {7'b0, irq_rst}, 8'h00);
    @(negedge clk);
    chk("R4 masked no irq late", {7'b0, irq_rst}, 8'h00);
    // R5 / R7 bus reset
    wr(2'd1, 8'h33);
    irq_rst_en = 1'b1;
    @(negedge clk);
    sie_bus_reset = 1'b1;
    @(negedge clk);
    sie_bus_reset = 1'b0;
    chk("R5 bus reset irq", {7'b0, irq_rst}, 8'h01);
    irq_rst_en = 1'b0;
    rd(2'd1, 8'h00, "R7 bus reset clears addr");
    // R3 suspend
    wr(2'd0, 8'h02);
    chk("R3 susp set", {7'b0, susp}, 8'h01);
    rd(2'd0, 8'h0A, "R3 ctrl susp");
    @(negedge clk);
    sie_activity = 1'b1;
    @(negedge clk);
    sie_activity = 1'b0;
    chk("R3 activity clears", {7'b0, susp}, 8'h00);
    rd(2'd0, 8'h08, "R3 ctrl after activity");
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h00);
    chk("R3 software clear", {7'b0, susp}, 8'h00);
    // R8 R9 R10 status
    xfer(2'b11, 2'd0, 1'b0);
    rd(2'd2, 8'hC0, "R8 setup ep0");
    xfer(2'b10, 2'd1, 1'b1);
    rd(2'd2, 8'hE8, "R9 ep1 in");
    xfer(2'b10, 2'd0, 1'b0);
    rd(2'd2, 8'hA0, "R9 ep0 keeps dir");
    xfer(2'b00, 2'd2, 1'b0);
    rd(2'd2, 8'h90, "R10 ep2 out");
    xfer(2'b11, 2'd3, 1'b1);
    rd(2'd2, 8'h90, "R10 ep3 ignored");
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h90, "R10 write ignored");
    xfer(2'b00, 2'd0, 1'b1);
    rd(2'd2, 8'h00, "R8 out ep0");
    // R12
    rd(2'd3, 8'h00, "R12 unused location");
    wr(2'd1, 8'h11);
    rd(2'd1, 8'h11, "R12 addr then");
    rd(2'd0, 8'h08, "R12 ctrl next");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule